// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

The block sits between a small bank of transmit mailboxes and a CAN bit engine. Each mailbox holds an identifier and a pending flag. While the engine is idle, the scheduler chooses one pending mailbox and starts an attempt with a one-cycle start pulse that carries the mailbox index and its identifier. The engine answers each attempt with one done pulse and a two-bit outcome. The scheduler then either retires the mailbox, recording the result, or leaves it pending so that it is tried again.

Two choosing policies can be switched at run time. In identifier mode the lowest identifier wins. In order mode, mailboxes are served in the order in which their requests arrived. A one-shot control turns off automatic retries: every attempt then retires its mailbox whatever the outcome. A pending mailbox that is not on the wire can be withdrawn. A withdrawn mailbox is retired with no outcome flag.

Top module: `can_txmb_sched`

## Requirements
- R1: After reset no mailbox is pending, all done and outcome flags are 0, and `eng_start` is low.
- R2: A `req_set` bit for a mailbox that is not pending loads `req_id` into that mailbox, marks it pending and clears its done and outcome flags. A `req_set` bit for a mailbox that is already pending is ignored, and its stored identifier is kept.
- R3: With `order_mode` = 0 the next attempt goes to the pending mailbox with the numerically lowest identifier. Equal identifiers go to the lower mailbox index.
- R4: With `order_mode` = 1 pending mailboxes are attempted in the order their requests were accepted. Requests accepted in the same cycle are ordered by lower index first. A withdrawn mailbox leaves the order of the rest unchanged.
- R5: `eng_start` is a single-cycle pulse for a pending mailbox. `eng_mb` and `eng_id` hold steady from that pulse until `eng_done`. No new choice and no new start happen while an attempt is outstanding.
- R6: With `one_shot` = 0, an outcome of arbitration lost (2'b01) or error (2'b10 or 2'b11) leaves the mailbox pending so that it is attempted again. Success (2'b00) retires it.
- R7: With `one_shot` = 1 every attempt retires its mailbox, whatever the outcome.
- R8: A retired mailbox has `tx_done` set and its pending flag cleared. Exactly one of `tx_ok`, `tx_arb` or `tx_err` is set, matching the outcome of the last attempt.
- R9: An `abort_req` bit retires a pending mailbox that is not in an outstanding attempt. Such a mailbox gets `tx_done` with no outcome flag. An abort aimed at the mailbox under attempt is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| order_mode | input | 1 | 0: identifier priority, 1: request order |
| one_shot | input | 1 | 1: no automatic retry |
| req_set | input | NUM_MB | Per-mailbox request strobe |
| req_id | input | ID_W | Identifier loaded by a request |
| abort_req | input | NUM_MB | Per-mailbox withdraw strobe |
| eng_start | output | 1 | Attempt start pulse to the engine |
| eng_mb | output | $clog2(NUM_MB) | Mailbox under attempt |
| eng_id | output | ID_W | Identifier under attempt |
| eng_done | input | 1 | Attempt finished pulse from the engine |
| eng_result | input | 2 | Outcome: 00 ok, 01 arbitration lost, 1x error |
| tx_pending | output | NUM_MB | Mailbox holds an unserved request |
| tx_done | output | NUM_MB | Mailbox retired |
| tx_ok | output | NUM_MB | Last attempt succeeded |
| tx_arb | output | NUM_MB | Last attempt lost arbitration |
| tx_err | output | NUM_MB | Last attempt ended in error |

## Verification
The choosing logic is swept over every identifier triple drawn from {0,1,2} across three mailboxes, combined with all six request arrival orders, in both policies. This separates identifier priority with its index tie-break from pure arrival order: the two policies disagree on most of these patterns. Directed sequences feed chains of arbitration-lost, error and ok outcomes with retries both allowed and barred, to show the difference between retrying and retiring. Further sequences withdraw waiting and in-flight mailboxes and re-request mailboxes that are already pending, so that ignored commands show up as an unchanged serve order and identifier.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
  typedef enum logic [1:0] {
    RES_OK  = 2'd0,
    RES_ARB = 2'd1,
    RES_ERR = 2'd2,
    RES_RSV = 2'd3
  } tx_result_e;
endpackage

// File: rtl/can_txmb_order.sv
// Arrival-rank tracker: every live mailbox holds its position in the request order.
module can_txmb_order #(
  parameter int NUM_MB = 3,
  parameter int RK_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_MB-1:0]              live,
  input  logic [NUM_MB-1:0]              push,
  input  logic [NUM_MB-1:0]              pop,
  output logic [NUM_MB-1:0][RK_W-1:0]    rank_o
);
  logic [NUM_MB-1:0][RK_W-1:0] rank_q, rank_d;
  logic [NUM_MB-1:0][RK_W-1:0] pre_push, drop;
  logic [NUM_MB-1:0]           keep;
  logic [RK_W-1:0]             cnt_keep;
  logic                        upd_en;

  always_comb begin
    keep     = live & ~pop;
    upd_en   = |{push, pop};
    cnt_keep = '0;
    for (int j = 0; j < NUM_MB; j++)
      if (keep[j]) cnt_keep = cnt_keep + RK_W'(1);
    for (int i = 0; i < NUM_MB; i++) begin
      pre_push[i] = '0;
      drop[i]     = '0;
      for (int j = 0; j < NUM_MB; j++) begin
        if (j < i && push[j]) pre_push[i] = pre_push[i] + RK_W'(1);
        if (pop[j] && (rank_q[j] < rank_q[i])) drop[i] = drop[i] + RK_W'(1);
      end
      if (push[i])      rank_d[i] = cnt_keep + pre_push[i];
      else if (keep[i]) rank_d[i] = rank_q[i] - drop[i];
      else              rank_d[i] = rank_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rank_q <= '0;
    else if (upd_en) rank_q <= rank_d;
  end

  assign rank_o = rank_q;
endmodule

// File: rtl/can_txmb_pick.sv
// Chooses one eligible mailbox: lowest identifier or lowest arrival rank.
module can_txmb_pick #(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 11,
  parameter int RK_W   = 2,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_MB-1:0]           elig,
  input  logic                        order_mode,
  input  logic [NUM_MB-1:0][ID_W-1:0] ids,
  input  logic [NUM_MB-1:0][RK_W-1:0] ranks,
  output logic                        any_o,
  output logic [IDX_W-1:0]            idx_o
);
  logic             id_found, rk_found;
  logic [ID_W-1:0]  id_best;
  logic [RK_W-1:0]  rk_best;
  logic [IDX_W-1:0] id_idx, rk_idx;

  always_comb begin
    id_found = 1'b0;
    id_best  = '0;
    id_idx   = '0;
    rk_found = 1'b0;
    rk_best  = '0;
    rk_idx   = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      // strict compare in ascending index order keeps the lower index on ties
      if (elig[i] && (!id_found || ids[i] < id_best)) begin
        id_found = 1'b1;
        id_best  = ids[i];
        id_idx   = IDX_W'(i);
      end
      if (elig[i] && (!rk_found || ranks[i] < rk_best)) begin
        rk_found = 1'b1;
        rk_best  = ranks[i];
        rk_idx   = IDX_W'(i);
      end
    end
    any_o = |elig;
    idx_o = order_mode ? rk_idx : id_idx;
  end
endmodule

// File: rtl/can_txmb_sched.sv
module can_txmb_sched
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 11,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
  localparam int RK_W  = $clog2(NUM_MB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              order_mode,
  input  logic              one_shot,
  input  logic [NUM_MB-1:0] req_set,
  input  logic [ID_W-1:0]   req_id,
  input  logic [NUM_MB-1:0] abort_req,
  output logic              eng_start,
  output logic [IDX_W-1:0]  eng_mb,
  output logic [ID_W-1:0]   eng_id,
  input  logic              eng_done,
  input  logic [1:0]        eng_result,
  output logic [NUM_MB-1:0] tx_pending,
  output logic [NUM_MB-1:0] tx_done,
  output logic [NUM_MB-1:0] tx_ok,
  output logic [NUM_MB-1:0] tx_arb,
  output logic [NUM_MB-1:0] tx_err
);
  // mailbox state
  logic [NUM_MB-1:0]           pend_q, pend_d;
  logic [NUM_MB-1:0]           done_q, done_d, ok_q, ok_d, arb_q, arb_d, err_q, err_d;
  logic [NUM_MB-1:0][ID_W-1:0] id_q;
  logic                        flag_en;
  // attempt sequencer
  logic                        busy_q, busy_d, start_q, start_d;
  logic [IDX_W-1:0]            cur_q, cur_d;
  // decoded controls
  logic [NUM_MB-1:0]           set_ok, cur_oh, in_prog, abort_ok, cmp_oh, pop, elig;
  logic                        fin_attempt, retire_cur, launch, pick_any;
  logic [IDX_W-1:0]            pick_idx;
  logic [NUM_MB-1:0][RK_W-1:0] ranks;
  tx_result_e                  res;

  always_comb begin
    res         = tx_result_e'(eng_result);
    set_ok      = req_set & ~pend_q;
    fin_attempt = busy_q & eng_done;
    retire_cur  = fin_attempt & ((res == RES_OK) | one_shot);
    for (int i = 0; i < NUM_MB; i++) cur_oh[i] = (cur_q == IDX_W'(i));
    in_prog     = busy_q ? cur_oh : '0;
    abort_ok    = abort_req & pend_q & ~in_prog;
    cmp_oh      = retire_cur ? cur_oh : '0;
    pop         = abort_ok | cmp_oh;
    elig        = pend_q & ~abort_ok;
  end

  can_txmb_order #(.NUM_MB(NUM_MB), .RK_W(RK_W)) u_order (
    .clk    (clk),
    .rst_n  (rst_n),
    .live   (pend_q),
    .push   (set_ok),
    .pop    (pop),
    .rank_o (ranks)
  );

  can_txmb_pick #(.NUM_MB(NUM_MB), .ID_W(ID_W), .RK_W(RK_W), .IDX_W(IDX_W)) u_pick (
    .elig       (elig),
    .order_mode (order_mode),
    .ids        (id_q),
    .ranks      (ranks),
    .any_o      (pick_any),
    .idx_o      (pick_idx)
  );

  // next state: mailbox flags
  always_comb begin
    pend_d  = (pend_q & ~pop) | set_ok;
    flag_en = |{set_ok, pop};
    done_d  = done_q;
    ok_d    = ok_q;
    arb_d   = arb_q;
    err_d   = err_q;
    for (int i = 0; i < NUM_MB; i++) begin
      if (set_ok[i]) begin
        done_d[i] = 1'b0;
        ok_d[i]   = 1'b0;
        arb_d[i]  = 1'b0;
        err_d[i]  = 1'b0;
      end else if (abort_ok[i]) begin
        done_d[i] = 1'b1;
        ok_d[i]   = 1'b0;
        arb_d[i]  = 1'b0;
        err_d[i]  = 1'b0;
      end else if (cmp_oh[i]) begin
        done_d[i] = 1'b1;
        ok_d[i]   = (res == RES_OK);
        arb_d[i]  = (res == RES_ARB);
        err_d[i]  = (res == RES_ERR) || (res == RES_RSV);
      end
    end
  end

  // next state: attempt sequencer (choice only while idle)
  always_comb begin
    launch  = !busy_q && pick_any;
    start_d = launch;
    cur_d   = launch ? pick_idx : cur_q;
    if (launch)           busy_d = 1'b1;
    else if (fin_attempt) busy_d = 1'b0;
    else                  busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      done_q <= '0;
      ok_q   <= '0;
      arb_q  <= '0;
      err_q  <= '0;
    end else if (flag_en) begin
      pend_q <= pend_d;
      done_q <= done_d;
      ok_q   <= ok_d;
      arb_q  <= arb_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
    end else begin
      for (int i = 0; i < NUM_MB; i++)
        if (set_ok[i]) id_q[i] <= req_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      cur_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      if (launch) cur_q <= cur_d;
    end
  end

  assign eng_start  = start_q;
  assign eng_mb     = cur_q;
  assign eng_id     = id_q[cur_q];
  assign tx_pending = pend_q;
  assign tx_done    = done_q;
  assign tx_ok      = ok_q;
  assign tx_arb     = arb_q;
  assign tx_err     = err_q;
endmodule

// File: rtl/can_txmb_chk.sv
module can_txmb_chk #(
  parameter int NUM_MB = 3,
  parameter int ID_W   = 11,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              one_shot,
  input logic [NUM_MB-1:0] abort_req,
  input logic              eng_start,
  input logic [IDX_W-1:0]  eng_mb,
  input logic [ID_W-1:0]   eng_id,
  input logic              eng_done,
  input logic [1:0]        eng_result,
  input logic [NUM_MB-1:0] tx_pending,
  input logic [NUM_MB-1:0] tx_done,
  input logic [NUM_MB-1:0] tx_ok,
  input logic [NUM_MB-1:0] tx_arb,
  input logic [NUM_MB-1:0] tx_err,
  input logic              busy_q,
  input logic [IDX_W-1:0]  cur_q
);
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_start_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> tx_pending[eng_mb]);

  assert_hold_attempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !eng_done) |=> ($stable(eng_mb) && $stable(eng_id)));

  assert_oneshot_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && eng_done && one_shot) |=> !tx_pending[$past(eng_mb)]);

  assert_retry_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && eng_done && !one_shot && eng_result != 2'b00) |=> tx_pending[$past(eng_mb)]);

  assert_abort_inflight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !eng_done && abort_req[cur_q]) |=> tx_pending[$past(cur_q)]);

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    assert_flag_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_ok[g], tx_arb[g], tx_err[g]}));
    assert_flag_has_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ok[g] || tx_arb[g] || tx_err[g]) |-> tx_done[g]);
    assert_done_not_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done[g] |-> !tx_pending[g]);
  end
endmodule

bind can_txmb_sched can_txmb_chk #(.NUM_MB(NUM_MB), .ID_W(ID_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .one_shot   (one_shot),
  .abort_req  (abort_req),
  .eng_start  (eng_start),
  .eng_mb     (eng_mb),
  .eng_id     (eng_id),
  .eng_done   (eng_done),
  .eng_result (eng_result),
  .tx_pending (tx_pending),
  .tx_done    (tx_done),
  .tx_ok      (tx_ok),
  .tx_arb     (tx_arb),
  .tx_err     (tx_err),
  .busy_q     (busy_q),
  .cur_q      (cur_q)
);

// File: tb/test_can_txmb_sched.sv
module test_can_txmb_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 4;
  localparam int IDW  = 11;
  localparam int IXW  = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           order_mode, one_shot;
  logic [NB-1:0]  req_set, abort_req;
  logic [IDW-1:0] req_id;
  logic           eng_start, eng_done;
  logic [IXW-1:0] eng_mb;
  logic [IDW-1:0] eng_id;
  logic [1:0]     eng_result;
  logic [NB-1:0]  tx_pending, tx_done, tx_ok, tx_arb, tx_err;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_txmb_sched #(.NUM_MB(NB), .ID_W(IDW)) i_can_txmb_sched (
    .clk(clk), .rst_n(rst_n), .order_mode(order_mode), .one_shot(one_shot),
    .req_set(req_set), .req_id(req_id), .abort_req(abort_req),
    .eng_start(eng_start), .eng_mb(eng_mb), .eng_id(eng_id),
    .eng_done(eng_done), .eng_result(eng_result),
    .tx_pending(tx_pending), .tx_done(tx_done), .tx_ok(tx_ok),
    .tx_arb(tx_arb), .tx_err(tx_err)
  );

  task automatic chk(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input int mb, input int id);
    req_set = NB'(1) << mb;
    req_id  = IDW'(id);
    @(negedge clk);
    req_set = '0;
  endtask

  task automatic do_abort(input logic [NB-1:0] bits);
    abort_req = bits;
    @(negedge clk);
    abort_req = '0;
  endtask

  task automatic wait_start(output int mb, output int id);
    int n = 0;
    while (eng_start !== 1'b1 && n < 40) begin
      @(negedge clk);
      n++;
    end
    if (eng_start !== 1'b1) begin
      tests++;
      fails++;
      $display("FAIL R5: no start, actual 0 expected 1");
    end
    mb = int'(eng_mb);
    id = int'(eng_id);
  endtask

  task automatic finish_attempt(input logic [1:0] res);
    eng_done   = 1'b1;
    eng_result = res;
    @(negedge clk);
    eng_done   = 1'b0;
    eng_result = 2'b00;
  endtask

  task automatic run_scenario(input int mode, input int i0, input int i1, input int i2,
                              input int p0, input int p1, input int p2);
    int ids[3];
    int perm[3];
    int exp_q[3];
    bit used[3];
    int mb, id;
    ids[0] = i0; ids[1] = i1; ids[2] = i2;
    perm[0] = p0; perm[1] = p1; perm[2] = p2;
    for (int k = 0; k < 3; k++) used[k] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (mode == 1) begin
        exp_q[k] = perm[k];
      end else begin
        int best = -1;
        for (int m = 0; m < 3; m++)
          if (!used[m] && (best < 0 || ids[m] * 4 + m < ids[best] * 4 + best)) best = m;
        exp_q[k] = best;
        used[best] = 1'b1;
      end
    end
    order_mode = mode[0];
    one_shot   = 1'b0;
    do_req(3, 0);
    wait_start(mb, id);
    for (int k = 0; k < 3; k++) do_req(perm[k], ids[perm[k]]);
    finish_attempt(2'b00);
    for (int k = 0; k < 3; k++) begin
      wait_start(mb, id);
      chk(mb, exp_q[k], (mode == 1) ? "R4 order-mode serve" : "R3 id-mode serve");
      finish_attempt(2'b00);
    end
    chk(int'(tx_ok[2:0]), 7, "R8 sweep ok flags");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int mb, id;
    rst_n = 1'b0; order_mode = 1'b0; one_shot = 1'b0;
    req_set = '0; abort_req = '0; req_id = '0;
    eng_done = 1'b0; eng_result = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(int'(tx_pending), 0, "R1 pending");
    chk(int'({tx_done, tx_ok, tx_arb, tx_err}), 0, "R1 flags");
    chk(int'(eng_start), 0, "R1 start");

    // R6 retry chain then success
    do_req(1, 5);
    wait_start(mb, id);
    chk(mb, 1, "R6 first attempt");
    finish_attempt(2'b01);
    chk(int'(tx_pending[1]), 1, "R6 kept after arb");
    chk(int'(tx_done[1]), 0, "R6 not done after arb");
    wait_start(mb, id);
    chk(mb, 1, "R6 retry after arb");
    finish_attempt(2'b10);
    chk(int'(tx_pending[1]), 1, "R6 kept after err");
    wait_start(mb, id);
    finish_attempt(2'b00);
    chk(int'({tx_done[1], tx_ok[1], tx_arb[1], tx_err[1], tx_pending[1]}), 5'b11000, "R8 ok retire");

    // R7 one-shot retires whatever the outcome
    one_shot = 1'b1;
    do_req(0, 3);
    wait_start(mb, id);
    finish_attempt(2'b01);
    chk(int'({tx_done[0], tx_ok[0], tx_arb[0], tx_err[0], tx_pending[0]}), 5'b10100, "R7 arb one-shot");
    do_req(0, 3);
    chk(int'(tx_done[0]), 0, "R2 done cleared on request");
    wait_start(mb, id);
    finish_attempt(2'b11);
    chk(int'({tx_done[0], tx_ok[0], tx_arb[0], tx_err[0], tx_pending[0]}), 5'b10010, "R7 err one-shot");
    do_req(0, 3);
    wait_start(mb, id);
    finish_attempt(2'b00);
    chk(int'({tx_done[0], tx_ok[0], tx_arb[0], tx_err[0]}), 4'b1100, "R7 ok one-shot");
    one_shot = 1'b0;

    // R5 no reselection while in flight
    order_mode = 1'b0;
    do_req(1, 7);
    wait_start(mb, id);
    chk(id, 7, "R5 start id");
    @(negedge clk);
    chk(int'(eng_start), 0, "R5 single-cycle start");
    do_req(0, 1);
    @(negedge clk);
    chk(int'(eng_mb), 1, "R5 mb held");
    chk(int'(eng_id), 7, "R5 id held");
    chk(int'(eng_start), 0, "R5 no restart");
    finish_attempt(2'b00);
    wait_start(mb, id);
    chk(mb, 0, "R3 waiting low id next");
    finish_attempt(2'b00);

    // R2 request on a pending mailbox ignored
    do_req(3, 0);
    wait_start(mb, id);
    do_req(2, 9);
    chk(int'(tx_ok[2]), 0, "R2 flags cleared");
    do_req(2, 1);
    do_req(1, 5);
    finish_attempt(2'b00);
    wait_start(mb, id);
    chk(mb, 1, "R2 ignored re-request");
    finish_attempt(2'b00);
    wait_start(mb, id);
    chk(id, 9, "R2 id kept");
    finish_attempt(2'b00);

    // R9 abort waiting and in-flight
    do_req(3, 0);
    wait_start(mb, id);
    do_req(0, 2);
    do_req(1, 3);
    do_abort(4'b0001);
    chk(int'({tx_done[0], tx_ok[0], tx_arb[0], tx_err[0], tx_pending[0]}), 5'b10000, "R9 abort waiting");
    do_abort(4'b1000);
    chk(int'(tx_pending[3]), 1, "R9 abort in-flight ignored");
    chk(int'(eng_mb), 3, "R9 attempt kept");
    finish_attempt(2'b00);
    chk(int'(tx_ok[3]), 1, "R9 in-flight completes ok");
    wait_start(mb, id);
    chk(mb, 1, "R9 next after abort");
    finish_attempt(2'b00);

    // R4 order kept around an abort
    order_mode = 1'b1;
    do_req(3, 0);
    wait_start(mb, id);
    do_req(2, 8);
    do_req(0, 1);
    do_req(1, 2);
    do_abort(4'b0001);
    finish_attempt(2'b00);
    wait_start(mb, id);
    chk(mb, 2, "R4 oldest after abort");
    finish_attempt(2'b00);
    wait_start(mb, id);
    chk(mb, 1, "R4 second after abort");
    finish_attempt(2'b00);

    // R3 / R4 sweep: identifiers {0,1,2}^3, all arrival orders, both modes
    for (int mode = 0; mode < 2; mode++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
          for (int c = 0; c < 3; c++)
            if (a != b && a != c && b != c)
              for (int i0 = 0; i0 < 3; i0++)
                for (int i1 = 0; i1 < 3; i1++)
                  for (int i2 = 0; i2 < 3; i2++)
                    run_scenario(mode, i0, i1, i2, a, b, c);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule